// File: doc/BRIEF.md
# Reloadable Constant-Coefficient Multiplier

This block multiplies an 8-bit unsigned sample by an 8-bit unsigned coefficient. The coefficient changes rarely and is written at run time. The sample is split into a low nibble and a high nibble. Each nibble addresses its own 16-entry table of partial products, where entry k holds k times the coefficient. The two table outputs are weighted, the high one by 16, and added into a registered 16-bit product.

Each table is a bank of 1-bit, 16-deep shift cells whose output bit is picked by the nibble address. When nothing is being shifted, the bank works as a plain lookup table. A new coefficient is written by a reload request. A sequencer then computes the 16 table entries by repeated subtraction, starting at 15 times the coefficient, and shifts them into both tables at once. After 16 shifts, entry k sits at address k. While the reload runs, the block reports busy and produces no results.

Top module: `coef_mult`

## Requirements
- R1: After reset, busy and res_vld are low, res is 0, and the coefficient is 0, so every accepted sample gives a product of 0. The reset is released through a two-stage synchronizer.
- R2: A sample with smp_vld high, in a cycle where busy is low and no reload is accepted, is accepted at that clock edge. After that edge, res_vld is high for exactly one cycle and res equals smp times the coefficient as a 16-bit unsigned value.
- R3: res keeps its value in every cycle where res_vld is low.
- R4: coef_ld sampled high while busy is low starts a reload with coef_in. busy rises after that edge and stays high for exactly 16 cycles.
- R5: While busy is high, res_vld stays low and smp_vld is ignored, so res does not change.
- R6: coef_ld while busy is high is ignored. The running reload keeps its coefficient and its 16-cycle length.
- R7: If smp_vld and an accepted coef_ld arrive in the same cycle, the reload wins and the sample is dropped: res_vld stays low and res is unchanged.
- R8: After a reload, every sample uses the new coefficient. This includes the extreme coefficients 0, 1 and 255 and the extreme samples 0 and 255.
- R9: The high nibble (bits 7:4) carries weight 16 and the low nibble (bits 3:0) weight 1. Samples 0x0F, 0xF0, 0x10 and 0x01 each give their own correct product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coef_ld | input | 1 | Request to load a new coefficient |
| coef_in | input | 8 | New coefficient value |
| smp_vld | input | 1 | Sample valid |
| smp | input | 8 | Variable sample |
| busy | output | 1 | Reload in progress |
| res_vld | output | 1 | Product valid, one cycle per accepted sample |
| res | output | 16 | Registered product |

## Verification
Two situations are the hardest to create from the ports. The first is a reload that is hit by further traffic while it runs. The bench holds smp_vld and a second coef_ld with a different value high for several cycles during busy. It then shows that res never moved and that the products use the first coefficient. The second is a sample that lands in the same cycle as the reload request. The bench raises both on the same falling edge and checks that the sample was dropped. Sweeps over nibble-boundary samples with coefficients 0, 1, 255 and mixed values confirm that every table address was rewritten.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_FILL = 1'b1
  } seq_st_e;
endpackage

// File: rtl/cm_shift_cell.sv
module cm_shift_cell #(
  parameter int AW = 4,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  input  logic [AW-1:0] addr,
  output logic          dout
);
  logic [DEPTH-1:0] cell_q;
  logic [DEPTH-1:0] cell_d;

  always_comb begin
    cell_d = cell_q;
    if (shift_en) cell_d = {cell_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cell_q <= '0;
    else        cell_q <= cell_d;
  end

  assign dout = cell_q[addr];
endmodule

// File: rtl/cm_pp_table.sv
module cm_pp_table #(
  parameter int AW = 4,
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic [PW-1:0] entry,
  input  logic [AW-1:0] addr,
  output logic [PW-1:0] pp
);
  for (genvar b = 0; b < PW; b++) begin : g_bit
    cm_shift_cell #(.AW(AW)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (entry[b]),
      .addr     (addr),
      .dout     (pp[b])
    );
  end
endmodule

// File: rtl/cm_reload_seq.sv
module cm_reload_seq
  import cm_pkg::*;
#(
  parameter int CW = 8,
  parameter int AW = 4,
  localparam int PW = CW + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] coef,
  output logic          busy,
  output logic          shift_en,
  output logic [PW-1:0] entry
);
  seq_st_e       st_q, st_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] acc_q, acc_d;
  logic [CW-1:0] cf_q, cf_d;
  logic [PW-1:0] top_entry;

  // entry at the highest address: coef * (2**AW - 1)
  assign top_entry = {coef, {AW{1'b0}}} - PW'(coef);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    acc_d = acc_q;
    cf_d  = cf_q;
    unique case (st_q)
      SEQ_IDLE: if (start) begin
        st_d  = SEQ_FILL;
        cnt_d = '1;
        acc_d = top_entry;
        cf_d  = coef;
      end
      SEQ_FILL: begin
        acc_d = acc_q - PW'(cf_q);
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == '0) st_d = SEQ_IDLE;
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      acc_q <= '0;
      cf_q  <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      acc_q <= acc_d;
      cf_q  <= cf_d;
    end
  end

  assign busy     = (st_q == SEQ_FILL);
  assign shift_en = busy;
  assign entry    = acc_q;
endmodule

// File: rtl/coef_mult.sv
module coef_mult #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int AW = 4,
  localparam int PW  = CW + AW,
  localparam int OW  = DW + CW,
  localparam int NSL = DW / AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          coef_ld,
  input  logic [CW-1:0] coef_in,
  input  logic          smp_vld,
  input  logic [DW-1:0] smp,
  output logic          busy,
  output logic          res_vld,
  output logic [OW-1:0] res
);
  logic [1:0]    rst_pipe_q;
  logic          rst_int_n;
  logic          ld_go, take, shift_en;
  logic [PW-1:0] entry;
  logic [PW-1:0] pp [NSL];
  logic [OW-1:0] sum;
  logic          vld_d;
  logic [OW-1:0] res_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  assign ld_go = coef_ld && !busy;
  assign take  = smp_vld && !busy && !coef_ld;

  cm_reload_seq #(.CW(CW), .AW(AW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (ld_go),
    .coef     (coef_in),
    .busy     (busy),
    .shift_en (shift_en),
    .entry    (entry)
  );

  for (genvar i = 0; i < NSL; i++) begin : g_tab
    cm_pp_table #(.AW(AW), .PW(PW)) u_tab (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .shift_en (shift_en),
      .entry    (entry),
      .addr     (smp[i*AW +: AW]),
      .pp       (pp[i])
    );
  end

  always_comb begin
    sum = '0;
    for (int i = 0; i < NSL; i++) sum = sum + (OW'(pp[i]) << (i * AW));
  end

  always_comb begin
    vld_d = take;
    res_d = take ? sum : res;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_vld <= 1'b0;
      res     <= '0;
    end else begin
      res_vld <= vld_d;
      res     <= res_d;
    end
  end
endmodule

// File: rtl/coef_mult_chk.sv
module coef_mult_chk #(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int AW = 4,
  localparam int OW  = DW + CW,
  localparam int LEN = 1 << AW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          coef_ld,
  input logic [CW-1:0] coef_in,
  input logic          smp_vld,
  input logic [DW-1:0] smp,
  input logic          busy,
  input logic          res_vld,
  input logic [OW-1:0] res
);
  logic [CW-1:0] shadow_q;
  logic [7:0]    blen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      blen_q   <= '0;
    end else begin
      if (coef_ld && !busy) shadow_q <= coef_in;
      blen_q <= busy ? blen_q + 8'd1 : 8'd0;
    end
  end

  // R5
  busy_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !res_vld);
  // R2
  valid_from_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> $past(smp_vld) && !$past(busy) && !$past(coef_ld));
  // R8
  product_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld |-> res == OW'($past(smp)) * OW'(shadow_q));
  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld |-> $stable(res));
  // R4
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(coef_ld));
  // R4
  reload_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> blen_q == 8'(LEN));
  // R6
  reload_no_extend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> blen_q < 8'(LEN));
endmodule

bind coef_mult coef_mult_chk #(.DW(DW), .CW(CW), .AW(AW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .coef_ld (coef_ld),
  .coef_in (coef_in),
  .smp_vld (smp_vld),
  .smp     (smp),
  .busy    (busy),
  .res_vld (res_vld),
  .res     (res)
);

// File: tb/sim_coef_mult.sv
`timescale 1ns/1ps
module sim_coef_mult;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        coef_ld;
  logic [7:0]  coef_in;
  logic        smp_vld;
  logic [7:0]  smp;
  logic        busy;
  logic        res_vld;
  logic [15:0] res;

  int checks = 0;
  int fails  = 0;
  logic [7:0] cur_coef;

  always #2.5 clk = ~clk;

  coef_mult u0 (
    .clk(clk), .rst_n(rst_n), .coef_ld(coef_ld), .coef_in(coef_in),
    .smp_vld(smp_vld), .smp(smp), .busy(busy), .res_vld(res_vld), .res(res)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [7:0] d);
    @(negedge clk);
    smp_vld = 1'b1; smp = d;
    @(negedge clk);
    smp_vld = 1'b0;
    check(req, {31'd0, res_vld}, 32'd1);
    check(req, {16'd0, res}, 32'(d) * 32'(cur_coef));
    @(negedge clk);
    check({req, " pulse"}, {31'd0, res_vld}, 32'd0);
  endtask

  // load a coefficient; optionally disturb the reload with samples and a second request
  task automatic load(input logic [7:0] c, input bit disturb, input logic [7:0] c2);
    logic [15:0] held;
    int n;
    held = res;
    @(negedge clk);
    coef_ld = 1'b1; coef_in = c;
    @(negedge clk);
    coef_ld = 1'b0;
    n = 0;
    while (busy && n < 40) begin
      n++;
      if (disturb && n >= 3 && n <= 8) begin
        smp_vld = 1'b1; smp = 8'hC3;
        coef_ld = 1'b1; coef_in = c2;
      end else begin
        smp_vld = 1'b0; coef_ld = 1'b0;
      end
      if (res_vld) check("R5 valid during reload", 32'd1, 32'd0);
      @(negedge clk);
    end
    smp_vld = 1'b0; coef_ld = 1'b0;
    check("R4 busy length", n, 32'd16);
    check("R5 res held over reload", {16'd0, res}, {16'd0, held});
    cur_coef = c;
  endtask

  task automatic t_reset();
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 res_vld", {31'd0, res_vld}, 32'd0);
    check("R1 res", {16'd0, res}, 32'd0);
    apply("R1 zero coefficient", 8'hFF);
  endtask

  task automatic t_sweep(input logic [7:0] c);
    load(c, 1'b0, 8'h00);
    apply("R8 sample 0", 8'h00);
    apply("R8 sample 255", 8'hFF);
    apply("R9 low nibble", 8'h0F);
    apply("R9 high nibble", 8'hF0);
    apply("R9 weight 16", 8'h10);
    apply("R9 weight 1", 8'h01);
    for (int k = 0; k < 16; k++) apply("R2 mixed", 8'((k * 37 + 5) & 8'hFF));
  endtask

  task automatic t_hold();
    logic [15:0] held;
    apply("R2 before hold", 8'h5A);
    held = res;
    repeat (4) @(negedge clk);
    check("R3 res holds", {16'd0, res}, {16'd0, held});
    check("R3 no valid", {31'd0, res_vld}, 32'd0);
  endtask

  task automatic t_disturb();
    load(8'h6B, 1'b1, 8'h11);
    apply("R6 first coefficient kept", 8'hD7);
    apply("R6 first coefficient kept", 8'h3C);
  endtask

  task automatic t_collide();
    logic [15:0] held;
    int n;
    held = res;
    @(negedge clk);
    coef_ld = 1'b1; coef_in = 8'h9E;
    smp_vld = 1'b1; smp = 8'h77;
    @(negedge clk);
    coef_ld = 1'b0; smp_vld = 1'b0;
    check("R7 sample dropped", {31'd0, res_vld}, 32'd0);
    check("R7 res unchanged", {16'd0, res}, {16'd0, held});
    check("R7 reload started", {31'd0, busy}, 32'd1);
    n = 0;
    while (busy && n < 40) begin n++; @(negedge clk); end
    check("R4 busy length after collision", n, 32'd16);
    cur_coef = 8'h9E;
    apply("R8 after collision", 8'h77);
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; coef_ld = 1'b0; coef_in = '0; smp_vld = 1'b0; smp = '0;
    cur_coef = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_sweep(8'h01);
    t_sweep(8'hFF);
    t_sweep(8'hA5);
    t_sweep(8'h00);
    t_sweep(8'h2D);
    t_hold();
    t_disturb();
    t_collide();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule